// File: doc/BRIEF.md
# Capability Access Guard

This block sits between a core's address generation and its memory port. For every load, store or instruction fetch it decides whether the capability that authorises the access permits it. The capability arrives already unpacked: a validity tag, a sealed flag, three permission bits, and a decoded 64-bit lower bound (base) and upper bound (top). The access arrives as a 64-bit address, a byte count and a kind. The block either grants the access or reports a fault together with a 3-bit cause code. The core's trap logic consumes that cause code.

The checks are combinational. A parameter selects an optional register stage at the output. With the default setting, the verdict for an access presented in one cycle appears after the next rising clock edge.

A pointer may hold any address, including one outside its bounds. Only an actual access through it is judged here.

Top module: `cap_access_guard`

## Requirements
- R1: An access with `acc_valid` high and `cap_tag` low faults with cause 1 (tag), whatever the other inputs are.
- R2: An access through a tagged capability with `cap_sealed` high faults with cause 2 (seal).
- R3: Each access kind needs its own permission bit. Kind 0 (load) needs `cap_perms[0]`, kind 1 (store) needs `cap_perms[1]` and kind 2 (fetch) needs `cap_perms[2]`. Kind 3 is reserved and always faults. Any of these permission failures on a tagged, unsealed capability gives cause 3.
- R4: An address below `cap_base` faults with cause 4 (bounds). An address equal to `cap_base` passes the lower check.
- R5: An access whose last byte lies beyond `cap_top` faults with cause 4. The access passes the upper check when address plus size equals `cap_top`, and also when size is 0 at address `cap_top`.
- R6: Address plus size is formed at 65 bits. An access that wraps past 2^64 therefore faults with cause 4, even when `cap_top` is all ones.
- R7: When several faults hold at once, the reported cause follows the priority tag > seal > permission > bounds.
- R8: An access that passes every check gives `chk_ok`=1, `chk_fault`=0 and `chk_cause`=0.
- R9: With `acc_valid` low, the outputs are `chk_ok`=0, `chk_fault`=0 and `chk_cause`=0.
- R10: With `REG_OUT`=1, the verdict appears after the first rising edge following the inputs and not before. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| acc_addr | input | ADDR_W (64) | Byte address of the access |
| acc_size | input | SIZE_W (5) | Number of bytes accessed |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability is sealed |
| cap_perms | input | 3 | Permission bits: bit 0 load, bit 1 store, bit 2 fetch |
| cap_base | input | ADDR_W (64) | Decoded lower bound, inclusive |
| cap_top | input | ADDR_W (64) | Decoded upper bound, exclusive |
| chk_ok | output | 1 | Access granted |
| chk_fault | output | 1 | Access refused |
| chk_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 permission, 4 bounds |

## Verification
The main function is exercised with several kinds of input pattern, each chosen to tell one decision apart from its neighbours:
- Clean accesses of every kind.
- Single-fault accesses, each with exactly one defect. These separate the four causes.
- Accesses with stacked defects, where tag, seal, permission and bounds faults are layered one over another. These show the priority order.
- Bounds probes placed at the base, one below the base, flush with top and one byte past it. These pin down the inclusive and exclusive ends of the range.
- An access that straddles the top of the 64-bit address space under a capability whose top is all ones. This separates a 65-bit sum from a truncated one.

Directed steps cover the idle state, reset, and the one-cycle delay of the output stage.

// File: rtl/cag_pkg.sv
package cag_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_SEAL   = 3'd2,
    CAUSE_PERM   = 3'd3,
    CAUSE_BOUNDS = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  localparam int PERM_W = 3;

  // Permission mask demanded by an access kind (empty for reserved kind).
  function automatic logic [PERM_W-1:0] perm_needed(input logic [1:0] kind);
    case (kind)
      KIND_LOAD:  perm_needed = 3'b001;
      KIND_STORE: perm_needed = 3'b010;
      KIND_FETCH: perm_needed = 3'b100;
      default:    perm_needed = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/cag_perm.sv
module cag_perm
  import cag_pkg::*;
(
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic [PERM_W-1:0] cap_perms,
  input  logic [1:0]        acc_kind,
  output logic              tag_bad,
  output logic              seal_bad,
  output logic              perm_bad
);

  logic [PERM_W-1:0] need_mask;

  always_comb begin
    need_mask = perm_needed(acc_kind);
    tag_bad   = ~cap_tag;
    seal_bad  = cap_sealed;
    perm_bad  = (need_mask == '0) || ((cap_perms & need_mask) == '0);
  end

  // R3
  always_comb begin
    if (!perm_bad && acc_kind == KIND_STORE)
      store_needs_w_chk: assert (cap_perms[1]);
  end

endmodule

// File: rtl/cag_bounds.sv
module cag_bounds #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W-1:0] cap_top,
  output logic              below_base,
  output logic              past_top
);

  localparam int SUM_W = ADDR_W + 1;

  // One-past-the-end of the access, one extra bit so wrap cannot hide.
  function automatic logic [SUM_W-1:0] access_end(
    input logic [ADDR_W-1:0] a,
    input logic [SIZE_W-1:0] s
  );
    access_end = {1'b0, a} + SUM_W'(s);
  endfunction

  logic [SUM_W-1:0] end_x;

  always_comb begin
    end_x      = access_end(acc_addr, acc_size);
    below_base = acc_addr < cap_base;
    past_top   = end_x > {1'b0, cap_top};
  end

  // R5
  always_comb begin
    if (!past_top)
      fit_below_top_chk: assert (acc_addr <= cap_top);
  end

  // R6
  always_comb begin
    if (!past_top)
      no_wrap_chk: assert (acc_size == '0 || ~acc_addr >= ADDR_W'(acc_size) - ADDR_W'(1));
  end

endmodule

// File: rtl/cag_resolve.sv
module cag_resolve
  import cag_pkg::*;
(
  input  logic       acc_valid,
  input  logic       tag_bad,
  input  logic       seal_bad,
  input  logic       perm_bad,
  input  logic       bounds_bad,
  output logic       ok_c,
  output logic       fault_c,
  output logic [2:0] cause_c
);

  cause_e cause_sel;

  always_comb begin
    if      (tag_bad)    cause_sel = CAUSE_TAG;
    else if (seal_bad)   cause_sel = CAUSE_SEAL;
    else if (perm_bad)   cause_sel = CAUSE_PERM;
    else if (bounds_bad) cause_sel = CAUSE_BOUNDS;
    else                 cause_sel = CAUSE_NONE;
    ok_c    = acc_valid && (cause_sel == CAUSE_NONE);
    fault_c = acc_valid && (cause_sel != CAUSE_NONE);
    cause_c = acc_valid ? cause_sel : CAUSE_NONE;
  end

  // R8
  always_comb begin
    excl_verdict_chk: assert ($onehot0({ok_c, fault_c}));
  end

  // R7
  always_comb begin
    if (fault_c && bounds_bad && (tag_bad || seal_bad || perm_bad))
      bounds_last_chk: assert (cause_c != CAUSE_BOUNDS);
  end

endmodule

// File: rtl/cap_access_guard.sv
module cap_access_guard
  import cag_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SIZE_W  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic [2:0]        cap_perms,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W-1:0] cap_top,
  output logic              chk_ok,
  output logic              chk_fault,
  output logic [2:0]        chk_cause
);

  logic tag_bad, seal_bad, perm_bad;
  logic below_base, past_top, bounds_bad;
  logic ok_c, fault_c;
  logic [2:0] cause_c;

  cag_perm u_perm (
    .cap_tag   (cap_tag),
    .cap_sealed(cap_sealed),
    .cap_perms (cap_perms),
    .acc_kind  (acc_kind),
    .tag_bad   (tag_bad),
    .seal_bad  (seal_bad),
    .perm_bad  (perm_bad)
  );

  cag_bounds #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .cap_base  (cap_base),
    .cap_top   (cap_top),
    .below_base(below_base),
    .past_top  (past_top)
  );

  assign bounds_bad = below_base | past_top;

  cag_resolve u_resolve (
    .acc_valid (acc_valid),
    .tag_bad   (tag_bad),
    .seal_bad  (seal_bad),
    .perm_bad  (perm_bad),
    .bounds_bad(bounds_bad),
    .ok_c      (ok_c),
    .fault_c   (fault_c),
    .cause_c   (cause_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chk_ok    <= 1'b0;
          chk_fault <= 1'b0;
          chk_cause <= 3'd0;
        end else begin
          chk_ok    <= ok_c;
          chk_fault <= fault_c;
          chk_cause <= cause_c;
        end
      end

      // R1
      tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cap_tag) |=> (chk_fault && chk_cause == CAUSE_TAG));

      // R9
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!chk_ok && !chk_fault && chk_cause == 3'd0));

      // R4
      under_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cap_tag && !cap_sealed && !perm_bad && acc_addr < cap_base)
        |=> (chk_cause == CAUSE_BOUNDS));
    end else begin : g_comb
      always_comb begin
        chk_ok    = ok_c;
        chk_fault = fault_c;
        chk_cause = cause_c;
      end
    end
  endgenerate

  // R8
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> (!chk_fault && chk_cause == 3'd0));

endmodule

// File: tb/test_cap_access_guard.sv
module test_cap_access_guard;

  localparam int AW = 64;
  localparam int SW = 5;
  localparam int VW = 1 + 1 + 3 + 2 + AW + AW + AW + SW + 3;
  localparam int NV = 17;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // tag, sealed, perms, kind, base, top, addr, size, expected cause
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h1000, 5'd8,  3'd0},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h1FF8, 5'd8,  3'd0},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h1FF9, 5'd8,  3'd4},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h0FFF, 5'd1,  3'd4},
    {1'b0, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd1},
    {1'b1, 1'b1, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd2},
    {1'b1, 1'b0, 3'd5, 2'd1, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd3},
    {1'b1, 1'b0, 3'd3, 2'd2, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd3},
    {1'b1, 1'b0, 3'd2, 2'd1, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd0},
    {1'b1, 1'b0, 3'd4, 2'd2, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd0},
    {1'b1, 1'b0, 3'd7, 2'd3, 64'h1000, 64'h2000, 64'h1100, 5'd4,  3'd3},
    {1'b0, 1'b1, 3'd0, 2'd0, 64'h1000, 64'h2000, 64'h3000, 5'd4,  3'd1},
    {1'b1, 1'b1, 3'd0, 2'd0, 64'h1000, 64'h2000, 64'h3000, 5'd4,  3'd2},
    {1'b1, 1'b0, 3'd0, 2'd0, 64'h1000, 64'h2000, 64'h3000, 5'd4,  3'd3},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h0,    ONES,     64'hFFFF_FFFF_FFFF_FFF8, 5'd16, 3'd4},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h0,    ONES,     64'hFFFF_FFFF_FFFF_FFF7, 5'd8,  3'd0},
    {1'b1, 1'b0, 3'd7, 2'd0, 64'h1000, 64'h2000, 64'h2000, 5'd0,  3'd0}
  };

  string vtag [NV] = '{"R8/R4", "R5", "R5", "R4", "R1", "R2", "R3", "R3", "R3",
                       "R3", "R3", "R7", "R7", "R7", "R6", "R6", "R5"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_kind = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [SW-1:0] acc_size = '0;
  logic          cap_tag = 1'b0;
  logic          cap_sealed = 1'b0;
  logic [2:0]    cap_perms = '0;
  logic [AW-1:0] cap_base = '0;
  logic [AW-1:0] cap_top = '0;
  logic          chk_ok, chk_fault;
  logic [2:0]    chk_cause;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cap_access_guard i_cap_access_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_size(acc_size), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_perms(cap_perms), .cap_base(cap_base),
    .cap_top(cap_top), .chk_ok(chk_ok), .chk_fault(chk_fault),
    .chk_cause(chk_cause)
  );

  task automatic expect_out(input string req, input logic ok_e,
                            input logic fault_e, input logic [2:0] cause_e);
    n_checks++;
    if (chk_ok !== ok_e || chk_fault !== fault_e || chk_cause !== cause_e) begin
      n_fails++;
      $display("FAIL %s: ok/fault/cause = %b/%b/%0d, expected %b/%b/%0d",
               req, chk_ok, chk_fault, chk_cause, ok_e, fault_e, cause_e);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    {cap_tag, cap_sealed, cap_perms, acc_kind, cap_base, cap_top,
     acc_addr, acc_size} = v[VW-1:3];
    acc_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    expect_out("R10 reset", 1'b0, 1'b0, 3'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      expect_out(vtag[i], VEC[i][2:0] == 3'd0, VEC[i][2:0] != 3'd0, VEC[i][2:0]);
    end

    // R9: idle with a bad capability on the inputs
    @(negedge clk);
    acc_valid = 1'b0;
    cap_tag = 1'b0;
    @(negedge clk);
    expect_out("R9 idle", 1'b0, 1'b0, 3'd0);

    // R10: verdict not visible before the edge, visible after it
    drive(VEC[4]);
    #2;
    expect_out("R10 before edge", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    expect_out("R10 after edge", 1'b0, 1'b1, 3'd1);

    // R10: reset clears a pending fault
    drive(VEC[2]);
    @(negedge clk);
    expect_out("R5 held", 1'b0, 1'b1, 3'd4);
    rst_n = 1'b0;
    #2;
    expect_out("R10 reset clears", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    acc_valid = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule